// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block manages low-power states for a small microcontroller core. Software writes a four-bit control register that holds a sleep-enable bit and a three-bit mode code. When the core then reports a sleep instruction with the enable bit set, the controller moves to the selected low-power state. It halts the core and drives five registered clock-domain enables from a per-mode table. The domains are CPU, I/O, ADC, asynchronous timer and oscillator.

An enabled interrupt wakes the controller. All clock enables come back at once. For the modes that stop the oscillator, a parameterised start-up count runs first. A fixed four-cycle halt follows, and then the core is released with a one-cycle interrupt-wake pulse, so it services the interrupt and continues after the sleep instruction. A system reset request clears the register. If that reset arrives while the core is halted, the controller also gives a one-cycle reset-wake pulse so the core restarts from its reset vector.

The controller issues no clear to core storage on any wake. A sleep instruction that selects a reserved mode code, or a standby mode without a crystal clock source, causes no state change and raises a one-cycle error pulse.

Top module: `sleep_power_ctrl`

## Requirements
- R1: After power-on reset `reg_rdata` is 0, `clk_en` is all ones, and `cpu_halt`, `asleep`, `irq_wake`, `rst_wake` and `sleep_err` are all 0.
- R2: A write with `reg_we` stores `reg_wdata` and reads back on `reg_rdata` from the next cycle. Bit 0 is the sleep enable and bits 3:1 are the mode code.
- R3: A sleep instruction while the sleep enable is 0 has no effect: the core is not halted and no error pulse is given.
- R4: A sleep instruction with the enable set and a valid mode sets `asleep` and `cpu_halt` from the next cycle. `clk_en` (bit 0 CPU, 1 I/O, 2 ADC, 3 async timer, 4 oscillator) then follows this table: 000 idle 5'b11110, 001 ADC quiet 5'b11100, 010 power-down 5'b00000, 011 power-save 5'b01000, 110 standby 5'b10000, 111 extended standby 5'b11000.
- R5: Mode codes 100 and 101 make a sleep instruction give a one-cycle `sleep_err` pulse in the next cycle, with no change of state or clock enables.
- R6: Modes 110 and 111 are accepted only while `xtal_src` is 1. Otherwise they behave as in R5.
- R7: In modes that keep the oscillator running (000, 001, 110, 111), `cpu_halt` stays high for exactly 4 cycles after the edge that samples `irq_req`. It then falls, together with a one-cycle `irq_wake` pulse.
- R8: In modes 010 and 011 the same interval is STARTUP_CYC + 4 cycles.
- R9: `irq_req` while the core is active has no effect.
- R10: `wake_rst` while the core is halted returns it to active, clears the register, restores all clock enables and pulses `rst_wake`. While the core is active, `wake_rst` only clears the register.
- R11: `clk_en` changes only in the cycle where `asleep` changes, and it is all ones whenever `asleep` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wake_rst | input | 1 | Synchronous system reset request |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Control register write data |
| reg_rdata | output | 4 | Control register contents |
| sleep_instr | input | 1 | Core executes a sleep instruction (one-cycle pulse) |
| irq_req | input | 1 | An enabled interrupt is pending |
| xtal_src | input | 1 | Clock source is an external crystal or resonator |
| cpu_halt | output | 1 | Core is held stopped |
| asleep | output | 1 | Controller is in a low-power state |
| clk_en | output | 5 | Registered clock-domain enables |
| irq_wake | output | 1 | One-cycle pulse: core released to service an interrupt |
| rst_wake | output | 1 | One-cycle pulse: wake by reset, restart from reset vector |
| sleep_err | output | 1 | One-cycle pulse: rejected sleep instruction |

## Verification
The assertions rely on the core behaving as a halted core does. It issues `sleep_instr` only as a single-cycle pulse, and never while `cpu_halt` is high. It does not write the register while halted. The bench drives every input on the falling edge. It raises `sleep_instr` only after the register write has settled, holds `irq_req` for one cycle while the controller is asleep, and asserts `wake_rst` for single cycles. This keeps every sequence inside those assumptions.

// File: rtl/spc_pkg.sv
package spc_pkg;
   localparam int MODE_W   = 3;
   localparam int REG_W    = MODE_W + 1;
   localparam int CE_W     = 5;
   localparam int HALT_CYC = 4;

   localparam int CE_CPU   = 0;
   localparam int CE_IO    = 1;
   localparam int CE_ADC   = 2;
   localparam int CE_ATMR  = 3;
   localparam int CE_OSC   = 4;

   typedef logic [MODE_W-1:0] spc_mode_t;
   typedef logic [CE_W-1:0]   spc_ce_t;

   localparam spc_mode_t MODE_IDLE  = 3'b000;
   localparam spc_mode_t MODE_ADCQ  = 3'b001;
   localparam spc_mode_t MODE_PDOWN = 3'b010;
   localparam spc_mode_t MODE_PSAVE = 3'b011;
   localparam spc_mode_t MODE_RSV0  = 3'b100;
   localparam spc_mode_t MODE_RSV1  = 3'b101;
   localparam spc_mode_t MODE_STBY  = 3'b110;
   localparam spc_mode_t MODE_XSTBY = 3'b111;

   localparam spc_ce_t CE_ALL = '1;

   typedef struct packed {
      spc_mode_t mode;
      logic      en;
   } spc_ctrl_t;

   typedef enum logic [1:0] {
      ST_ACTIVE  = 2'd0,
      ST_SLEEP   = 2'd1,
      ST_STARTUP = 2'd2,
      ST_HALT    = 2'd3
   } spc_state_e;
endpackage

// File: rtl/spc_ctrl_reg.sv
module spc_ctrl_reg
   import spc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output spc_ctrl_t        ctrl
);
   if ($bits(spc_ctrl_t) != REG_W) begin : g_bad_width
      $error("spc_ctrl_reg: control struct width mismatch");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (clr) begin
         ctrl <= '0;
      end else if (we) begin
         ctrl <= spc_ctrl_t'(wdata);
      end
   end
endmodule

// File: rtl/spc_mode_decode.sv
module spc_mode_decode
   import spc_pkg::*;
#(
   parameter int STARTUP_CYC = 16
) (
   input  spc_mode_t mode,
   input  logic      xtal_src,
   output logic      mode_ok,
   output spc_ce_t   sleep_ce,
   output logic      need_startup
);
   logic osc_stops;

   always_comb begin
      mode_ok  = 1'b1;
      sleep_ce = '0;
      unique case (mode)
         MODE_IDLE: begin
            sleep_ce[CE_IO]   = 1'b1;
            sleep_ce[CE_ADC]  = 1'b1;
            sleep_ce[CE_ATMR] = 1'b1;
            sleep_ce[CE_OSC]  = 1'b1;
         end
         MODE_ADCQ: begin
            sleep_ce[CE_ADC]  = 1'b1;
            sleep_ce[CE_ATMR] = 1'b1;
            sleep_ce[CE_OSC]  = 1'b1;
         end
         MODE_PDOWN: sleep_ce = '0;
         MODE_PSAVE: sleep_ce[CE_ATMR] = 1'b1;
         MODE_STBY: begin
            sleep_ce[CE_OSC] = 1'b1;
            mode_ok          = xtal_src;
         end
         MODE_XSTBY: begin
            sleep_ce[CE_ATMR] = 1'b1;
            sleep_ce[CE_OSC]  = 1'b1;
            mode_ok           = xtal_src;
         end
         default: begin
            mode_ok  = 1'b0;
            sleep_ce = CE_ALL;
         end
      endcase
   end

   assign osc_stops = ~sleep_ce[CE_OSC];

   if (STARTUP_CYC == 0) begin : g_no_startup
      assign need_startup = 1'b0;
      logic unused_osc;
      assign unused_osc = osc_stops;
   end else begin : g_startup
      assign need_startup = osc_stops;
   end
endmodule

// File: rtl/spc_wake_seq.sv
module spc_wake_seq
   import spc_pkg::*;
#(
   parameter int STARTUP_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wake_rst,
   input  logic       sleep_instr,
   input  logic       sleep_en,
   input  logic       mode_ok,
   input  spc_ce_t    sleep_ce,
   input  logic       need_startup,
   input  logic       irq_req,
   output spc_state_e state,
   output spc_ce_t    clk_en,
   output logic       irq_wake,
   output logic       rst_wake,
   output logic       sleep_err
);
   localparam int LONGEST = (STARTUP_CYC > HALT_CYC) ? STARTUP_CYC : HALT_CYC;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam int SU_LOAD = (STARTUP_CYC > 0) ? STARTUP_CYC - 1 : 0;

   logic [CNT_W-1:0] cnt;
   logic             slow_wake;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_ACTIVE;
         cnt       <= '0;
         clk_en    <= CE_ALL;
         slow_wake <= 1'b0;
         irq_wake  <= 1'b0;
         rst_wake  <= 1'b0;
         sleep_err <= 1'b0;
      end else begin
         irq_wake  <= 1'b0;
         rst_wake  <= 1'b0;
         sleep_err <= 1'b0;
         if (wake_rst) begin
            rst_wake <= (state != ST_ACTIVE);
            state    <= ST_ACTIVE;
            clk_en   <= CE_ALL;
            cnt      <= '0;
         end else begin
            unique case (state)
               ST_ACTIVE: begin
                  if (sleep_instr && sleep_en) begin
                     if (mode_ok) begin
                        state     <= ST_SLEEP;
                        clk_en    <= sleep_ce;
                        slow_wake <= need_startup;
                     end else begin
                        sleep_err <= 1'b1;
                     end
                  end
               end
               ST_SLEEP: begin
                  if (irq_req) begin
                     clk_en <= CE_ALL;
                     if (slow_wake) begin
                        state <= ST_STARTUP;
                        cnt   <= CNT_W'(SU_LOAD);
                     end else begin
                        state <= ST_HALT;
                        cnt   <= CNT_W'(HALT_CYC - 1);
                     end
                  end
               end
               ST_STARTUP: begin
                  if (cnt == '0) begin
                     state <= ST_HALT;
                     cnt   <= CNT_W'(HALT_CYC - 1);
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               ST_HALT: begin
                  if (cnt == '0) begin
                     state    <= ST_ACTIVE;
                     irq_wake <= 1'b1;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               default: state <= ST_ACTIVE;
            endcase
         end
      end
   end
endmodule

// File: rtl/sleep_power_ctrl.sv
module sleep_power_ctrl
   import spc_pkg::*;
#(
   parameter int STARTUP_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wake_rst,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             sleep_instr,
   input  logic             irq_req,
   input  logic             xtal_src,
   output logic             cpu_halt,
   output logic             asleep,
   output logic [CE_W-1:0]  clk_en,
   output logic             irq_wake,
   output logic             rst_wake,
   output logic             sleep_err
);
   if (STARTUP_CYC < 0 || STARTUP_CYC > 65535) begin : g_bad_startup
      $error("sleep_power_ctrl: STARTUP_CYC out of range");
   end

   spc_ctrl_t  ctrl;
   logic       mode_ok;
   spc_ce_t    sleep_ce;
   logic       need_startup;
   spc_state_e state;

   spc_ctrl_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wake_rst),
      .we    (reg_we),
      .wdata (reg_wdata),
      .ctrl  (ctrl)
   );

   spc_mode_decode #(.STARTUP_CYC(STARTUP_CYC)) u_dec (
      .mode         (ctrl.mode),
      .xtal_src     (xtal_src),
      .mode_ok      (mode_ok),
      .sleep_ce     (sleep_ce),
      .need_startup (need_startup)
   );

   spc_wake_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .wake_rst     (wake_rst),
      .sleep_instr  (sleep_instr),
      .sleep_en     (ctrl.en),
      .mode_ok      (mode_ok),
      .sleep_ce     (sleep_ce),
      .need_startup (need_startup),
      .irq_req      (irq_req),
      .state        (state),
      .clk_en       (clk_en),
      .irq_wake     (irq_wake),
      .rst_wake     (rst_wake),
      .sleep_err    (sleep_err)
   );

   assign reg_rdata = ctrl;
   assign cpu_halt  = (state != ST_ACTIVE);
   assign asleep    = (state == ST_SLEEP);
endmodule

// File: rtl/spc_checker.sv
module spc_checker
   import spc_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             wake_rst,
   input logic [REG_W-1:0] reg_rdata,
   input logic             sleep_instr,
   input logic             cpu_halt,
   input logic             asleep,
   input logic [CE_W-1:0]  clk_en,
   input logic             irq_wake,
   input logic             rst_wake,
   input logic             sleep_err
);
   a_r3_no_sleep_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_halt && sleep_instr && !reg_rdata[0] && !wake_rst) |=> (!cpu_halt && !sleep_err));

   a_r5_err_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_err |-> (!cpu_halt && $past(sleep_instr) && clk_en == CE_ALL));

   a_r7_halt_before_release: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wake |-> (!cpu_halt && $past(cpu_halt, 1) && $past(cpu_halt, 2)
                    && $past(cpu_halt, 3) && $past(cpu_halt, 4)
                    && !$past(asleep, 1) && !$past(asleep, 2)
                    && !$past(asleep, 3) && !$past(asleep, 4)));

   a_r10_reset_wake_state: assert property (@(posedge clk) disable iff (!rst_n)
      rst_wake |-> (!cpu_halt && reg_rdata == '0 && clk_en == CE_ALL && $past(cpu_halt)));

   a_r11_ce_change_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_en) |-> (asleep != $past(asleep)));

   a_r11_ce_full_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
      !asleep |-> (clk_en == CE_ALL));

   a_r4_sleep_implies_halt: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> cpu_halt);

   a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_wake, rst_wake, sleep_err}));
endmodule

bind sleep_power_ctrl spc_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wake_rst    (wake_rst),
   .reg_rdata   (reg_rdata),
   .sleep_instr (sleep_instr),
   .cpu_halt    (cpu_halt),
   .asleep      (asleep),
   .clk_en      (clk_en),
   .irq_wake    (irq_wake),
   .rst_wake    (rst_wake),
   .sleep_err   (sleep_err)
);

// File: tb/sleep_power_ctrl_bench.sv
module sleep_power_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SU         = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wake_rst = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic       sleep_instr = 1'b0;
   logic       irq_req = 1'b0;
   logic       xtal_src = 1'b1;
   logic       cpu_halt;
   logic       asleep;
   logic [4:0] clk_en;
   logic       irq_wake;
   logic       rst_wake;
   logic       sleep_err;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sleep_power_ctrl #(.STARTUP_CYC(SU)) u_sleep_power_ctrl (
      .clk (clk), .rst_n (rst_n), .wake_rst (wake_rst),
      .reg_we (reg_we), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .sleep_instr (sleep_instr), .irq_req (irq_req), .xtal_src (xtal_src),
      .cpu_halt (cpu_halt), .asleep (asleep), .clk_en (clk_en),
      .irq_wake (irq_wake), .rst_wake (rst_wake), .sleep_err (sleep_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [4:0] exp_ce(input logic [2:0] m);
      case (m)
         3'b000:  return 5'b11110;
         3'b001:  return 5'b11100;
         3'b010:  return 5'b00000;
         3'b011:  return 5'b01000;
         3'b110:  return 5'b10000;
         3'b111:  return 5'b11000;
         default: return 5'b11111;
      endcase
   endfunction

   task automatic write_reg(input logic [3:0] v);
      reg_we = 1'b1; reg_wdata = v;
      step();
      reg_we = 1'b0;
   endtask

   task automatic issue_sleep(input logic [2:0] m, input logic en);
      write_reg({m, en});
      sleep_instr = 1'b1;
      step();
      sleep_instr = 1'b0;
   endtask

   task automatic wake_and_measure(input string req, input int exp_len);
      int n = 0;
      irq_req = 1'b1;
      step();
      irq_req = 1'b0;
      chk({req, " clk_en restored on wake"}, clk_en, 5'b11111);
      while (cpu_halt && n < 200) begin
         n++;
         step();
      end
      chk({req, " halt length"}, n, exp_len);
      chk({req, " irq_wake pulse"}, irq_wake, 1);
      step();
      chk({req, " irq_wake single cycle"}, irq_wake, 0);
   endtask

   task automatic t_reset();
      chk("R1 reg_rdata", reg_rdata, 0);
      chk("R1 clk_en", clk_en, 5'b11111);
      chk("R1 cpu_halt", cpu_halt, 0);
      chk("R1 asleep", asleep, 0);
      chk("R1 pulses", {irq_wake, rst_wake, sleep_err}, 0);
   endtask

   task automatic t_reg_rw();
      write_reg(4'b1011);
      chk("R2 readback a", reg_rdata, 4'b1011);
      write_reg(4'b0100);
      chk("R2 readback b", reg_rdata, 4'b0100);
   endtask

   task automatic t_disabled();
      issue_sleep(3'b010, 1'b0);
      chk("R3 no halt", cpu_halt, 0);
      chk("R3 no error", sleep_err, 0);
      chk("R3 clk_en", clk_en, 5'b11111);
   endtask

   task automatic t_modes();
      logic [2:0] list [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110, 3'b111};
      xtal_src = 1'b1;
      foreach (list[i]) begin
         issue_sleep(list[i], 1'b1);
         chk($sformatf("R4 asleep mode %0d", list[i]), asleep, 1);
         chk($sformatf("R4 clk_en mode %0d", list[i]), clk_en, exp_ce(list[i]));
         step(); step();
         chk($sformatf("R11 clk_en held mode %0d", list[i]), clk_en, exp_ce(list[i]));
         if (list[i] == 3'b010 || list[i] == 3'b011)
            wake_and_measure($sformatf("R8 mode %0d", list[i]), SU + 4);
         else
            wake_and_measure($sformatf("R7 mode %0d", list[i]), 4);
      end
   endtask

   task automatic t_reserved();
      for (int m = 4; m <= 5; m++) begin
         issue_sleep(3'(m), 1'b1);
         chk("R5 error pulse", sleep_err, 1);
         chk("R5 no halt", cpu_halt, 0);
         chk("R5 clk_en", clk_en, 5'b11111);
         step();
         chk("R5 pulse ends", sleep_err, 0);
      end
   endtask

   task automatic t_standby_src();
      xtal_src = 1'b0;
      issue_sleep(3'b110, 1'b1);
      chk("R6 standby no xtal error", sleep_err, 1);
      chk("R6 standby no xtal active", cpu_halt, 0);
      issue_sleep(3'b111, 1'b1);
      chk("R6 ext standby no xtal error", sleep_err, 1);
      xtal_src = 1'b1;
      issue_sleep(3'b110, 1'b1);
      chk("R6 standby with xtal sleeps", asleep, 1);
      chk("R6 no error with xtal", sleep_err, 0);
      wake_and_measure("R6 standby wake", 4);
   endtask

   task automatic t_irq_active();
      irq_req = 1'b1;
      step(); step();
      irq_req = 1'b0;
      chk("R9 active irq no halt", cpu_halt, 0);
      chk("R9 active irq no wake pulse", irq_wake, 0);
   endtask

   task automatic t_reset_wake();
      issue_sleep(3'b010, 1'b1);
      chk("R10 asleep before reset", asleep, 1);
      step(); step();
      wake_rst = 1'b1;
      step();
      wake_rst = 1'b0;
      chk("R10 rst_wake pulse", rst_wake, 1);
      chk("R10 active after reset", cpu_halt, 0);
      chk("R10 reg cleared", reg_rdata, 0);
      chk("R10 clk_en restored", clk_en, 5'b11111);
      chk("R10 no irq_wake", irq_wake, 0);
      step();
      chk("R10 rst_wake single", rst_wake, 0);
      write_reg(4'b0111);
      wake_rst = 1'b1;
      step();
      wake_rst = 1'b0;
      chk("R10 active reset clears reg", reg_rdata, 0);
      chk("R10 active reset no rst_wake", rst_wake, 0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_reg_rw();
      t_disabled();
      t_modes();
      t_reserved();
      t_standby_src();
      t_irq_active();
      t_reset_wake();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule